// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Clock Divider

This block divides its input clock by a ratio that is not limited to whole numbers. A down-counter sets the length of every output period. At each period boundary it reloads with the integer base N plus a small signed offset. A modulus sequencer picks that offset so that, over time, the periods average N + F/2^16. Here F is a 16-bit fractional word.

The sequencer has two modes. In first-order mode it is a single phase accumulator, and each period is either N or N+1. In second-order mode two cascaded accumulators form a noise-shaping modulator. The offset then ranges from -1 to +2, so periods of N-1 to N+2 occur. The average is kept, but the regular pattern is broken up so that it no longer produces spurious tones. The output is a pulse one input clock wide at the last clock of each period. A signed offset output shows which divisor the current period uses.

N, F and the mode are read only at a period boundary. A period that is already running keeps the length it was given. The active-low reset clears both accumulators and the counter.

Top module: `fracn_div`

## Requirements
- R1: While reset is asserted and right after its release, pulse_o is 0 and ofs_o is 0. The first pulse_o is seen after exactly N rising clock edges following release.
- R2: pulse_o is high for exactly one clock, at the last clock of each output period.
- R3: Each output period lasts N + ofs_o input clocks. ofs_o is held for the whole period and changes only on the clock edge that follows a pulse.
- R4: With order2_i = 0, ofs_o is 0 or 1. Starting from a cleared accumulator, the phase advances by F at each boundary. A period uses N+1 exactly when the 16-bit phase wraps, so F = 16'h4000 gives the offsets 0,0,0,1 repeating.
- R5: When F = 0 and the block starts from reset, every period lasts exactly N clocks, in either mode.
- R6: With order2_i = 1, the offset is the first-stage wrap plus the second-stage wrap minus the second-stage wrap of the previous boundary. It lies in -1..+2, encoded as 3-bit two's complement. From reset with F = 16'h4000, the first eight offsets are 0,0,1,0,0,1,0,0. The sum of the offsets over the first L periods is floor(L*F/2^16) or one more.
- R7: A change of N, F or order2_i in the middle of a period does not change that period. The next boundary uses the new values.
- R8: N may be any value from 4 to 255. The smallest period that can occur, N = 4 with offset -1, is 3 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| n_i | input | 8 | Integer base divisor N (4..255) |
| frac_i | input | 16 | Fractional word F, in units of 2^-16 |
| order2_i | input | 1 | 1 selects the second-order modulator, 0 the first-order accumulator |
| pulse_o | output | 1 | One-clock pulse at the end of each output period |
| ofs_o | output | 3 | Signed divisor offset of the current period |

## Verification
The assertions assume that n_i stays within 4..255. Under that assumption every period is at least three clocks long, so a pulse can never follow a pulse. They also assume that F and the mode are read only at boundaries, which is how the zero-fraction and first-order offset properties are stated. The bench changes inputs only at negative clock edges. It keeps N within the legal range, including the minimum of 4, and changes N and F in mid-period only in the test that checks those changes are deferred.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned N_W    = 8;
  localparam int unsigned FRAC_W = 16;
  localparam int unsigned OFS_W  = 3;
  typedef logic signed [OFS_W-1:0] ofs_t;
endpackage

// File: rtl/fracn_acc.sv
module fracn_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic [W-1:0] add_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   total;

  assign total   = {1'b0, acc_q} + {1'b0, add_i};
  assign sum_o   = total[W-1:0];
  assign carry_o = total[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (en_i)  acc_q <= clr_i ? '0 : sum_o;
  end
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_pkg::*;
#(
  parameter int unsigned FW = FRAC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          order2_i,
  input  logic [FW-1:0] frac_i,
  output ofs_t          ofs_o
);
  localparam int unsigned STAGES = 2;

  logic [FW-1:0]     add_w [STAGES];
  logic [FW-1:0]     sum_w [STAGES];
  logic [STAGES-1:0] cy_w;
  logic              c2_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign add_w[k] = frac_i;
    end else begin : g_tail
      assign add_w[k] = sum_w[k-1];
    end
    fracn_acc #(.W(FW)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (step_i),
      .clr_i  ((k > 0) && !order2_i),
      .add_i  (add_w[k]),
      .sum_o  (sum_w[k]),
      .carry_o(cy_w[k])
    );
  end

  // second-stage carry of the previous boundary, for the difference term
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      c2_q <= 1'b0;
    else if (step_i)  c2_q <= order2_i ? cy_w[1] : 1'b0;
  end

  ofs_t c1_s, c2_s, c2q_s;
  assign c1_s  = ofs_t'({2'b00, cy_w[0]});
  assign c2_s  = ofs_t'({2'b00, cy_w[1]});
  assign c2q_s = ofs_t'({2'b00, c2_q});
  assign ofs_o = order2_i ? (c1_s + c2_s - c2q_s) : c1_s;
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt
  import fracn_pkg::*;
#(
  parameter int unsigned NW = N_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_i,
  input  ofs_t          ofs_i,
  output logic          bnd_o,
  output logic          pulse_o,
  output ofs_t          ofs_o
);
  localparam int unsigned CNT_W = NW + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load;

  assign load    = {1'b0, n_i} + {{(CNT_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
  assign bnd_o   = (cnt_q <= CNT_W'(1));
  assign pulse_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ofs_o <= '0;
    end else if (bnd_o) begin
      cnt_q <= load;
      ofs_o <= ofs_i;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/fracn_div.sv
module fracn_div
  import fracn_pkg::*;
#(
  parameter int unsigned NW = N_W,
  parameter int unsigned FW = FRAC_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NW-1:0]       n_i,
  input  logic [FW-1:0]       frac_i,
  input  logic                order2_i,
  output logic                pulse_o,
  output logic signed [2:0]   ofs_o
);
  logic bnd;
  ofs_t ofs_nxt;
  ofs_t ofs_cur;

  fracn_mash #(.FW(FW)) u_mash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (bnd),
    .order2_i(order2_i),
    .frac_i  (frac_i),
    .ofs_o   (ofs_nxt)
  );

  fracn_cnt #(.NW(NW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .n_i    (n_i),
    .ofs_i  (ofs_nxt),
    .bnd_o  (bnd),
    .pulse_o(pulse_o),
    .ofs_o  (ofs_cur)
  );

  assign ofs_o = ofs_cur;
endmodule

// File: rtl/fracn_div_chk.sv
module fracn_div_chk #(
  parameter int unsigned FW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_o,
  input logic signed [2:0] ofs_o,
  input logic              bnd,
  input logic              order2_i,
  input logic [FW-1:0]     frac_i
);
  // R6
  ofs_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_o >= -3'sd1) && (ofs_o <= 3'sd2));

  // R2
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R3
  ofs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_o |=> $stable(ofs_o));

  // R4
  order1_ofs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && !order2_i) |=> ((ofs_o == 3'sd0) || (ofs_o == 3'sd1)));

  // R5
  zero_frac_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && !order2_i && (frac_i == '0)) |=> (ofs_o == 3'sd0));
endmodule

bind fracn_div fracn_div_chk #(.FW(FW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pulse_o (pulse_o),
  .ofs_o   (ofs_o),
  .bnd     (bnd),
  .order2_i(order2_i),
  .frac_i  (frac_i)
);

// File: tb/fracn_div_bench.sv
`timescale 1ns/1ps
module fracn_div_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        n_i = 8'd10;
  logic [15:0]       frac_i = '0;
  logic              order2_i = 1'b0;
  logic              pulse;
  logic signed [2:0] ofs;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  fracn_div u_fracn_div (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .n_i     (n_i),
    .frac_i  (frac_i),
    .order2_i(order2_i),
    .pulse_o (pulse),
    .ofs_o   (ofs)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset(input int n, input int f, input bit o2);
    rst_n = 1'b0;
    n_i = 8'(n);
    frac_i = 16'(f);
    order2_i = o2;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // counts clocks from the previous pulse (or reset release) up to the next pulse
  task automatic next_period(input int start, output int len, output int o);
    len = start;
    do begin
      @(negedge clk);
      len++;
    end while (!pulse && len < 2000);
    if (len >= 2000) chk(1'b0, "R2 timeout", len, 0);
    o = int'(ofs);
  endtask

  task automatic t_reset();
    int len, o;
    rst_n = 1'b0;
    #1;
    chk(pulse == 1'b0, "R1 pulse in reset", int'(pulse), 0);
    do_reset(10, 0, 1'b0);
    chk(pulse == 1'b0, "R1 pulse after release", int'(pulse), 0);
    chk(ofs == 3'sd0, "R1 ofs after release", int'(ofs), 0);
    next_period(0, len, o);
    chk(len == 10, "R1 first pulse delay", len, 10);
  endtask

  task automatic t_exact();
    int len, o;
    do_reset(7, 0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      next_period(0, len, o);
      chk(len == 7 && o == 0, "R5 exact N order1", len, 7);
    end
    @(negedge clk);
    chk(pulse == 1'b0, "R2 pulse width", int'(pulse), 0);
    next_period(1, len, o);
    chk(len == 7, "R2 period after width probe", len, 7);
    do_reset(5, 0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      next_period(0, len, o);
      chk(len == 5 && o == 0, "R5 exact N order2", len, 5);
    end
  endtask

  task automatic t_first_order();
    int len, o, hits;
    int exp_o [4] = '{0, 0, 0, 1};
    hits = 0;
    do_reset(9, 16'h4000, 1'b0);
    for (int i = 0; i < 64; i++) begin
      next_period(0, len, o);
      if (o == 1) hits++;
      if (i < 8) begin
        chk(o == exp_o[i % 4], "R4 first-order pattern", o, exp_o[i % 4]);
        chk(len == 9 + o, "R3 period equals N+ofs", len, 9 + o);
      end
    end
    chk(hits == 16, "R4 N+1 count over 64", hits, 16);
  endtask

  task automatic t_second_order();
    int len, o, sum;
    int exp_o [8] = '{0, 0, 1, 0, 0, 1, 0, 0};
    sum = 0;
    do_reset(9, 16'h4000, 1'b1);
    for (int i = 0; i < 64; i++) begin
      next_period(0, len, o);
      sum += o;
      if (i < 8) chk(o == exp_o[i], "R6 second-order pattern", o, exp_o[i]);
    end
    chk(sum == 16, "R6 offset sum over 64", sum, 16);
  endtask

  task automatic t_min_n();
    int len, o, sum, bad, minlen;
    sum = 0; bad = 0; minlen = 100;
    do_reset(4, 16'h9e37, 1'b1);
    for (int i = 0; i < 200; i++) begin
      next_period(0, len, o);
      sum += o;
      if (len < minlen) minlen = len;
      if (len != 4 + o || o < -1 || o > 2) bad++;
    end
    chk(bad == 0, "R8 N=4 periods match N+ofs", bad, 0);
    chk(minlen >= 3, "R8 shortest period", minlen, 3);
    chk(sum == 123 || sum == 124, "R6 offset sum over 200", sum, 123);
  endtask

  task automatic t_change();
    int len, o;
    do_reset(10, 0, 1'b0);
    next_period(0, len, o);
    repeat (3) @(negedge clk);
    n_i = 8'd6;
    next_period(3, len, o);
    chk(len == 10, "R7 N change deferred", len, 10);
    next_period(0, len, o);
    chk(len == 6, "R7 new N applied", len, 6);
    repeat (2) @(negedge clk);
    frac_i = 16'h8000;
    next_period(2, len, o);
    chk(len == 6 && o == 0, "R7 F change deferred", len, 6);
    next_period(0, len, o);
    chk(o == 0, "R7 new F first step", o, 0);
    next_period(0, len, o);
    chk(o == 1 && len == 7, "R7 new F second step", len, 7);
  endtask

  initial begin
    t_reset();
    t_exact();
    t_first_order();
    t_second_order();
    t_min_n();
    t_change();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule